// File: doc/BRIEF.md
# Audio Capture Ring Buffer Controller

This block takes a stream of audio sample words, aligns each one to the right of a 24-bit stored word according to a selected sample width, and writes it into an internal ring buffer. A host drains the buffer through a read stream, and can see the current write and read positions as word indices. Capture runs only while the record control is high. A synchronous clear empties the buffer, resets both positions, drops all pending flags and restarts the test generator.

Three sticky status flags drive a single interrupt line: a fill-level flag, an overrun flag and a flag raised by an external receiver event. Each flag has its own enable. For testing the path without a real source, a generator can replace the incoming samples with a constant pattern or with a pseudo-random sequence.

The input stream never applies back-pressure: `in_ready` is always high. A beat that cannot be stored is dropped, and a beat dropped because the buffer is full is reported as an overrun. The output stream follows valid/ready rules: `out_valid` is high whenever the buffer holds a word, `out_data` stays stable until that word is taken, and a word is removed on a cycle where both `out_valid` and `out_ready` are high.

Top module: `audio_cap_ring`

## Requirements
- R1: After reset, and one cycle after `clear` is pulsed, both positions read 0, `out_valid` is 0 and `status` is 000.
- R2: An input beat is stored only while `record` is 1. With `record` at 0 a beat leaves `wr_ptr` unchanged.
- R3: The stored word is `in_data >> (24 - n)`, zero-extended, where n is the sample width chosen by `fmt_sel`: 00 gives 16, 01 gives 18, 10 gives 20 and 11 gives 24. Incoming samples are MSB-aligned in `in_data`.
- R4: Words leave the buffer in arrival order. A word is taken when `out_valid` and `out_ready` are both 1, and `rd_ptr` then advances by one.
- R5: `wr_ptr` and `rd_ptr` are word indices modulo the depth (2**ADDR_W words, 32 by default). `wr_ptr` advances by one for each stored word.
- R6: A beat that arrives while recording and while the buffer holds the full depth is dropped, leaves `wr_ptr` unchanged and sets `status[1]` (overrun). This holds even if a word is taken in the same cycle.
- R7: `status[0]` (level) sets on the cycle the fill count first becomes equal to the threshold. `lvl_sel` selects the threshold: 01 gives depth/8, 10 gives depth/4, 11 gives depth/2, and 00 never sets the flag. A push and a pop in the same cycle leave the count unchanged and do not set the flag.
- R8: The flags are sticky. A 1 in bit i of `stat_clr` clears `status[i]`. If a flag is set and cleared in the same cycle, the set takes effect.
- R9: `irq` = (`status[0]` and `lvl_sel`≠00) or (`status[1]` and `ovr_en`) or (`status[2]` and `ext_en`).
- R10: With `test_en`=1 and `test_sel`=0, every stored word is 0x000055, whatever `in_data` holds.
- R11: With `test_en`=1 and `test_sel`=1, the stored words follow a 16-bit LFSR (zero-extended). The LFSR starts from 0xACE1 and, on every input beat, shifts left taking in s15^s13^s12^s10. Each beat stores the value the LFSR held before that shift. Reset and `clear` restore the start value.
- R12: `in_ready` is always 1.
- R13: A pulse on `ext_evt` sets `status[2]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Synchronous buffer, pointer, flag and generator clear |
| record | input | 1 | Capture enable |
| fmt_sel | input | 2 | Sample width select |
| test_en | input | 1 | Replace input samples with generated data |
| test_sel | input | 1 | Generator: 0 constant 0x55, 1 LFSR |
| in_valid | input | 1 | Input sample beat |
| in_ready | output | 1 | Always 1 |
| in_data | input | 24 | MSB-aligned input sample |
| out_valid | output | 1 | Buffer holds a word |
| out_ready | input | 1 | Host takes the word |
| out_data | output | 24 | Oldest stored word |
| wr_ptr | output | ADDR_W | Write word index |
| rd_ptr | output | ADDR_W | Read word index |
| lvl_sel | input | 2 | Fill threshold select |
| ovr_en | input | 1 | Overrun interrupt enable |
| ext_en | input | 1 | External event interrupt enable |
| ext_evt | input | 1 | External receiver event pulse |
| stat_clr | input | 3 | Write-one-to-clear strobes for status |
| status | output | 3 | {external, overrun, level} |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of functions can act in the same cycle. The first pair is push and pop: with three words held and a depth/8 threshold (four words), the bench raises `in_valid` and `out_ready` together for one cycle and checks that the level flag stays clear. A lone push afterwards must then set it. The second pair is the flag set and the host clear: with the buffer full, an overrun beat is driven in the same cycle as `stat_clr[1]`, and the overrun flag must remain set.

// File: rtl/acr_pkg.sv
package acr_pkg;
  localparam logic [15:0] LFSR_SEED = 16'hACE1;
  localparam int SAMPLE_W = 24;

  typedef enum logic [1:0] {
    FMT_16 = 2'b00,
    FMT_18 = 2'b01,
    FMT_20 = 2'b10,
    FMT_24 = 2'b11
  } fmt_e;

  typedef struct packed {
    logic ext;
    logic ovr;
    logic lvl;
  } stat_t;

  function automatic logic [15:0] lfsr_next(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction
endpackage

// File: rtl/acr_sample_fmt.sv
module acr_sample_fmt
  import acr_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                beat,
  input  logic [SAMPLE_W-1:0] raw,
  input  logic [1:0]          fmt_sel,
  input  logic                test_en,
  input  logic                test_sel,
  output logic [SAMPLE_W-1:0] word
);
  logic [15:0]          lfsr_q;
  logic [SAMPLE_W-1:0]  aligned;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          lfsr_q <= LFSR_SEED;
    else if (clear)                      lfsr_q <= LFSR_SEED;
    else if (beat && test_en && test_sel) lfsr_q <= lfsr_next(lfsr_q);
  end

  always_comb begin
    unique case (fmt_e'(fmt_sel))
      FMT_16:  aligned = raw >> (SAMPLE_W - 16);
      FMT_18:  aligned = raw >> (SAMPLE_W - 18);
      FMT_20:  aligned = raw >> (SAMPLE_W - 20);
      default: aligned = raw;
    endcase
  end

  always_comb begin
    if (!test_en)      word = aligned;
    else if (test_sel) word = SAMPLE_W'(lfsr_q);
    else               word = SAMPLE_W'(8'h55);
  end

  // R11: the generator never reaches the all-zero lock-up state
  p_lfsr_live_r11: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != 16'h0000);
endmodule

// File: rtl/acr_ring.sv
module acr_ring #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic [ADDR_W-1:0] wr_ptr,
  output logic [ADDR_W-1:0] rd_ptr,
  output logic [ADDR_W:0]   count,
  output logic [ADDR_W:0]   count_nxt,
  output logic              full,
  output logic              empty,
  output logic              ovr_evt
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              do_wr;
  logic              do_rd;

  assign full    = (count == (ADDR_W+1)'(DEPTH));
  assign empty   = (count == '0);
  assign do_wr   = push && !full;
  assign do_rd   = pop && !empty;
  assign ovr_evt = push && full;
  assign dout    = mem[rd_ptr];

  always_comb begin
    count_nxt = count;
    if (do_wr && !do_rd)      count_nxt = count + 1'b1;
    else if (do_rd && !do_wr) count_nxt = count - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clear) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_wr) wr_ptr <= wr_ptr + 1'b1;
      if (do_rd) rd_ptr <= rd_ptr + 1'b1;
      count <= count_nxt;
    end
  end

  // R6: the fill count never exceeds the depth
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    count <= (ADDR_W+1)'(DEPTH));

  // R6: a beat into a full buffer leaves the write index in place
  p_drop_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !clear) |=> wr_ptr == $past(wr_ptr));

  // R4: a taken word moves the read index by one
  p_pop_adv_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !empty && !clear) |=> rd_ptr == ADDR_W'($past(rd_ptr) + 1'b1));

  // R5: the distance between the indices matches the fill count
  p_ptr_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ADDR_W'(wr_ptr - rd_ptr) == count[ADDR_W-1:0]);
endmodule

// File: rtl/acr_irq.sv
module acr_irq
  import acr_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic [ADDR_W:0] count,
  input  logic [ADDR_W:0] count_nxt,
  input  logic            ovr_evt,
  input  logic            ext_evt,
  input  logic [1:0]      lvl_sel,
  input  logic            ovr_en,
  input  logic            ext_en,
  input  logic [2:0]      stat_clr,
  output logic [2:0]      status,
  output logic            irq
);
  localparam int DEPTH = 1 << ADDR_W;

  stat_t           stat_q;
  stat_t           set_v;
  logic [ADDR_W:0] thr;
  logic            lvl_on;

  assign lvl_on = (lvl_sel != 2'b00);

  always_comb begin
    unique case (lvl_sel)
      2'b01:   thr = (ADDR_W+1)'(DEPTH / 8);
      2'b10:   thr = (ADDR_W+1)'(DEPTH / 4);
      default: thr = (ADDR_W+1)'(DEPTH / 2);
    endcase
  end

  always_comb begin
    set_v.lvl = lvl_on && (count_nxt == thr) && (count != thr);
    set_v.ovr = ovr_evt;
    set_v.ext = ext_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     stat_q <= '0;
    else if (clear) stat_q <= '0;
    else            stat_q <= (stat_q & ~stat_t'(stat_clr)) | set_v;
  end

  assign status = stat_q;
  assign irq    = (stat_q.lvl && lvl_on) || (stat_q.ovr && ovr_en) ||
                  (stat_q.ext && ext_en);

  // R8: without a clear strobe a raised overrun flag stays raised
  p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q.ovr && !stat_clr[1] && !clear) |=> stat_q.ovr);

  // R8: a set that meets a clear in the same cycle still leaves the flag set
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_evt && !clear) |=> stat_q.ovr);

  // R7: with threshold select 00 the level flag never rises
  p_lvl_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!lvl_on && !stat_q.lvl) |=> !stat_q.lvl);
endmodule

// File: rtl/audio_cap_ring.sv
module audio_cap_ring
  import acr_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                record,
  input  logic [1:0]          fmt_sel,
  input  logic                test_en,
  input  logic                test_sel,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [23:0]         in_data,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [23:0]         out_data,
  output logic [ADDR_W-1:0]   wr_ptr,
  output logic [ADDR_W-1:0]   rd_ptr,
  input  logic [1:0]          lvl_sel,
  input  logic                ovr_en,
  input  logic                ext_en,
  input  logic                ext_evt,
  input  logic [2:0]          stat_clr,
  output logic [2:0]          status,
  output logic                irq
);
  logic [SAMPLE_W-1:0] word;
  logic [ADDR_W:0]     count;
  logic [ADDR_W:0]     count_nxt;
  logic                full;
  logic                empty;
  logic                ovr_evt;
  logic                push;

  assign in_ready  = 1'b1;
  assign push      = in_valid && record;
  assign out_valid = !empty;

  acr_sample_fmt u_fmt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear),
    .beat     (in_valid),
    .raw      (in_data),
    .fmt_sel  (fmt_sel),
    .test_en  (test_en),
    .test_sel (test_sel),
    .word     (word)
  );

  acr_ring #(.ADDR_W(ADDR_W), .DATA_W(SAMPLE_W)) u_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .push      (push),
    .pop       (out_ready),
    .din       (word),
    .dout      (out_data),
    .wr_ptr    (wr_ptr),
    .rd_ptr    (rd_ptr),
    .count     (count),
    .count_nxt (count_nxt),
    .full      (full),
    .empty     (empty),
    .ovr_evt   (ovr_evt)
  );

  acr_irq #(.ADDR_W(ADDR_W)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .count     (count),
    .count_nxt (count_nxt),
    .ovr_evt   (ovr_evt),
    .ext_evt   (ext_evt),
    .lvl_sel   (lvl_sel),
    .ovr_en    (ovr_en),
    .ext_en    (ext_en),
    .stat_clr  (stat_clr),
    .status    (status),
    .irq       (irq)
  );

  // R2: with record low the write index does not move
  p_no_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!record && !clear) |=> wr_ptr == $past(wr_ptr));

  // R1: one cycle after clear the buffer is empty and no flag is pending
  p_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!out_valid && status == 3'b000));
endmodule

// File: tb/audio_cap_ring_tb_top.sv
module audio_cap_ring_tb_top;
  localparam int AW    = 5;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear = 0, record = 0, test_en = 0, test_sel = 0;
  logic [1:0] fmt_sel = 0, lvl_sel = 0;
  logic in_valid = 0, out_ready = 0, ovr_en = 0, ext_en = 0, ext_evt = 0;
  logic [23:0] in_data = 0;
  logic [2:0] stat_clr = 0;
  logic in_ready, out_valid, irq;
  logic [23:0] out_data;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [2:0] status;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [23:0] q[$];
  logic [15:0] lf = 16'hACE1;

  always #5 clk = ~clk;

  audio_cap_ring #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .clear(clear), .record(record),
    .fmt_sel(fmt_sel), .test_en(test_en), .test_sel(test_sel),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .lvl_sel(lvl_sel),
    .ovr_en(ovr_en), .ext_en(ext_en), .ext_evt(ext_evt),
    .stat_clr(stat_clr), .status(status), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // driver: one input beat, expected word pushed to the scoreboard
  task automatic push(input logic [23:0] raw);
    logic [23:0] e;
    int n;
    n = (fmt_sel == 2'b00) ? 16 : (fmt_sel == 2'b01) ? 18 :
        (fmt_sel == 2'b10) ? 20 : 24;
    if (!test_en)      e = raw >> (24 - n);
    else if (test_sel) e = {8'h00, lf};
    else               e = 24'h000055;
    if (test_en && test_sel) lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    if (record && q.size() < DEPTH) q.push_back(e);
    in_valid = 1'b1;
    in_data  = raw;
    step();
    in_valid = 1'b0;
  endtask

  task automatic drain();
    out_ready = 1'b1;
    while (q.size() > 0) step();
    out_ready = 1'b0;
  endtask

  task automatic do_clear();
    clear = 1'b1;
    step();
    clear = 1'b0;
    q.delete();
    lf = 16'hACE1;
  endtask

  // monitor: compares each taken word with the scoreboard head (R4, R3)
  always @(negedge clk) begin
    if (rst_n && out_ready) begin
      if (q.size() == 0) begin
        chk(!out_valid, "R4 out_valid with empty model", out_valid, 0);
      end else begin
        chk(out_valid, "R4 out_valid", out_valid, 1);
        chk(out_data == q[0], "R4/R3 data order", out_data, q[0]);
        void'(q.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1 / R12 reset state
    chk(wr_ptr == 0 && rd_ptr == 0, "R1 ptrs after reset", {wr_ptr, rd_ptr}, 0);
    chk(!out_valid, "R1 empty after reset", out_valid, 0);
    chk(status == 0 && !irq, "R1 status after reset", {irq, status}, 0);
    chk(in_ready, "R12 in_ready", in_ready, 1);

    // R2 no capture when record low
    push(24'h123456); push(24'h654321); push(24'h111111);
    chk(wr_ptr == 0, "R2 no capture without record", wr_ptr, 0);
    chk(!out_valid, "R2 still empty", out_valid, 0);

    // R3 formats, R5 pointer counting
    record = 1'b1;
    for (int f = 0; f < 4; f++) begin
      fmt_sel = f[1:0];
      push(24'hABCDEF);
      push(24'h80_0001 + 24'(f * 24'h010203));
    end
    chk(wr_ptr == 8, "R5 wr_ptr after 8 words", wr_ptr, 8);
    chk(out_valid, "R4 out_valid with data", out_valid, 1);
    drain();
    chk(rd_ptr == 8, "R5 rd_ptr after drain", rd_ptr, 8);
    chk(!out_valid, "R4 empty after drain", out_valid, 0);

    // R7 level at depth/8, concurrent push/pop does not trigger
    fmt_sel = 2'b11;
    lvl_sel = 2'b01;
    push(24'h000001); push(24'h000002); push(24'h000003);
    chk(status[0] == 0, "R7 below threshold", status, 0);
    out_ready = 1'b1;
    push(24'h000004);
    out_ready = 1'b0;
    chk(status[0] == 0, "R7 push+pop same cycle no level", status, 0);
    push(24'h000005);
    chk(status[0] == 1, "R7 level at depth/8", status, 1);
    chk(irq == 1, "R9 level irq", irq, 1);
    lvl_sel = 2'b00;
    #1;
    chk(irq == 0, "R9 level irq masked by 00", irq, 0);
    stat_clr = 3'b001; step(); stat_clr = 3'b000;
    chk(status == 0, "R8 w1c level", status, 0);
    push(24'h000006);
    chk(status[0] == 0, "R7 select 00 never sets", status, 0);
    drain();

    // R6 overrun, R7 depth/2 during fill
    lvl_sel = 2'b11;
    ovr_en = 1'b1;
    for (int i = 0; i < DEPTH; i++) push(24'(i * 24'h000101));
    chk(status == 3'b001, "R7 level at depth/2", status, 1);
    stat_clr = 3'b001; step(); stat_clr = 3'b000;
    begin
      logic [AW-1:0] w0;
      w0 = wr_ptr;
      push(24'hDEAD00);
      chk(wr_ptr == w0, "R6 wr_ptr held when full", wr_ptr, w0);
    end
    chk(status[1] == 1, "R6 overrun flag", status, 3'b010);
    chk(irq == 1, "R9 overrun irq", irq, 1);
    ovr_en = 1'b0;
    #1;
    chk(irq == 0, "R9 overrun irq masked", irq, 0);
    stat_clr = 3'b010;
    push(24'hBEEF00);
    stat_clr = 3'b000;
    chk(status[1] == 1, "R8 set wins over clear", status, 3'b010);
    stat_clr = 3'b010; step(); stat_clr = 3'b000;
    chk(status[1] == 0, "R8 w1c overrun", status, 0);
    // full and a pop in the same cycle: beat still dropped
    out_ready = 1'b1;
    push(24'hCAFE00);
    out_ready = 1'b0;
    chk(status[1] == 1, "R6 overrun with concurrent pop", status, 3'b010);
    drain();
    stat_clr = 3'b111; step(); stat_clr = 3'b000;
    lvl_sel = 2'b00;

    // R13 external flag
    ext_evt = 1'b1; step(); ext_evt = 1'b0;
    chk(status == 3'b100, "R13 ext flag", status, 3'b100);
    chk(irq == 0, "R9 ext masked", irq, 0);
    ext_en = 1'b1;
    #1;
    chk(irq == 1, "R9 ext irq", irq, 1);
    stat_clr = 3'b100; step(); stat_clr = 3'b000;
    chk(status == 0 && irq == 0, "R8 w1c ext", {irq, status}, 0);

    // R10 constant pattern
    test_en = 1'b1; test_sel = 1'b0;
    push(24'hFFFFFF); push(24'h123456);
    drain();
    // R11 LFSR sequence
    test_sel = 1'b1;
    for (int i = 0; i < 6; i++) push(24'h0F0F0F);
    drain();

    // R1 clear, R11 seed restored
    for (int i = 0; i < 3; i++) push(24'h0);
    ext_evt = 1'b1; step(); ext_evt = 1'b0;
    do_clear();
    chk(wr_ptr == 0 && rd_ptr == 0, "R1 ptrs after clear", {wr_ptr, rd_ptr}, 0);
    chk(!out_valid && status == 0, "R1 empty after clear", {out_valid, status}, 0);
    push(24'h0); push(24'h0);
    chk(q[0] == 24'h00ACE1, "R11 model seed", q[0], 24'h00ACE1);
    drain();
    test_en = 1'b0;
    chk(rd_ptr == 2, "R5 rd_ptr after clear run", rd_ptr, 2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule